// File: doc/BRIEF.md
# Packet Verdict Core

A compact in-order processor that runs a small eBPF-style program over a single packet and hands back a forwarding verdict. The host first writes the program into instruction memory and the packet bytes into a local buffer. It then pulses the start input with the packet length applied. The core clears its working state, executes one instruction per cycle, and raises a one-cycle done strobe with a 3-bit verdict.

Instructions are fixed 64-bit words. Bits [7:0] hold the opcode, [11:8] the destination, [15:12] source A, [19:16] source B, [31:20] a signed jump/memory offset and [63:32] a signed immediate. Opcode bits [7:4] select the class: 0 ALU register form, 1 ALU immediate form, 2 load, 3 store, 4 jump, 5 exit. ALU sub-ops in bits [3:0] are 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 move B. Load and store sub-op bit 3 selects the stack (1) or the packet (0), and bits [2:0] select the size: 0 is 1 byte, 1 is 2, 2 is 4, 3 is 6 and 4 is 8. Jump sub-op bit 3 selects an immediate B, and bits [2:0] give the condition: 0 always, 1 equal, 2 not equal, 3 unsigned greater, 4 unsigned greater-or-equal. A taken jump goes to pc+1+offset.

Exit 0x50 to 0x54 returns the verdict held in its low three bits. Exit 0x58 returns r0[2:0]. The verdict codes are ABORTED=0, DROP=1, PASS=2, TX=3 and REDIRECT=4. Memory addresses are the value in source A plus the offset. Memory is byte-addressed and read and written in little-endian order.

Top module: `pkt_core`

## Requirements
- R1: Reset leaves done_o low and verdict_o at 0. Each run goes IDLE, CLEAR, RUN, DONE. done_o is high for exactly one cycle per run. start_i has no effect outside IDLE.
- R2: ALU instructions write dst = A op B, where B is a register or the sign-extended immediate. Both sources keep their values unless one of them is the destination.
- R3: Loads of 1, 2, 4, 6 and 8 bytes return little-endian data that is zero-extended to 64 bits. A 6-byte load clears bits [63:48] of the destination.
- R4: Stores write exactly the selected number of bytes, low byte first, to the stack or to the packet.
- R5: An exit with opcode 0x50+v (v from 0 to 4) returns v, whatever r0 holds.
- R6: Plain exit (0x58) returns r0[2:0].
- R7: Before each run, r0 to r10 and the whole stack are zeroed. Then r1 is set to 0 (the packet start) and r2 to the packet length (the packet end).
- R8: A packet access whose last byte lies at or beyond the packet length aborts with verdict 0. This includes negative effective addresses.
- R9: The run aborts with verdict 0 when a 4097th instruction would execute. A program of exactly 4096 instructions completes normally.
- R10: Jumps follow the condition encoding given above, with unsigned compares and a target of pc+1+offset.
- R11: An undefined opcode, a size code above 4, or a register field above 10 aborts with verdict 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction memory write enable |
| imem_addr_i | input | 6 | Instruction memory write address |
| imem_data_i | input | 64 | Instruction word |
| pkt_we_i | input | 1 | Packet buffer byte write enable |
| pkt_addr_i | input | 8 | Packet buffer byte address |
| pkt_data_i | input | 8 | Packet byte |
| pkt_len_i | input | 9 | Packet length in bytes, captured at start |
| start_i | input | 1 | Start strobe, honoured only in IDLE |
| done_o | output | 1 | One-cycle completion strobe |
| verdict_o | output | 3 | Verdict of the last run |

## Verification
The bench probes the packet-length bound at its exact edge. An 8-byte read of an 8-byte packet must pass, while a 2-byte read at offset 7, a read at the end offset, and a store at offset -1 must all abort. An off-by-one comparator would either abort legal accesses or let reads run past the packet. The watchdog is checked at 4096 and at 4097 executed instructions, which catches a counter that is off by one. A second run checks that state left by a first run is gone. The 6-byte load goes into a register that was all ones, and the 6-byte store must leave its neighbouring bytes zero, so a width decode that copies 8 bytes or skips the zero-extend shows up in the verdict. A re-pulse of start during a run must not produce a second done strobe.

// File: rtl/pkt_core_pkg.sv
package pkt_core_pkg;
  localparam logic [2:0] V_ABORT = 3'd0;
  localparam logic [2:0] V_DROP  = 3'd1;
  localparam logic [2:0] V_PASS  = 3'd2;
  localparam logic [2:0] V_TX    = 3'd3;
  localparam logic [2:0] V_REDIR = 3'd4;

  localparam logic [3:0] CL_ALU_R = 4'h0;
  localparam logic [3:0] CL_ALU_I = 4'h1;
  localparam logic [3:0] CL_LD    = 4'h2;
  localparam logic [3:0] CL_ST    = 4'h3;
  localparam logic [3:0] CL_JMP   = 4'h4;
  localparam logic [3:0] CL_EXIT  = 4'h5;

  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_RUN, S_DONE} state_e;

  typedef struct packed {
    logic [31:0] imm;
    logic [11:0] off;
    logic [3:0]  src_b;
    logic [3:0]  src_a;
    logic [3:0]  dst;
    logic [7:0]  opc;
  } instr_t;

  function automatic logic [3:0] acc_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pkt_core_alu.sv
module pkt_core_alu (
  input  logic [3:0]  op_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  output logic [63:0] y_o,
  output logic        ok_o
);
  always_comb begin
    ok_o = 1'b1;
    case (op_i)
      4'h0:    y_o = a_i + b_i;
      4'h1:    y_o = a_i - b_i;
      4'h2:    y_o = a_i & b_i;
      4'h3:    y_o = a_i | b_i;
      4'h4:    y_o = a_i ^ b_i;
      4'h5:    y_o = a_i << b_i[5:0];
      4'h6:    y_o = a_i >> b_i[5:0];
      4'h7:    y_o = b_i;
      default: begin y_o = '0; ok_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pkt_core_cond.sv
module pkt_core_cond (
  input  logic [2:0]  op_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  output logic        take_o,
  output logic        ok_o
);
  always_comb begin
    ok_o = 1'b1;
    case (op_i)
      3'd0:    take_o = 1'b1;
      3'd1:    take_o = (a_i == b_i);
      3'd2:    take_o = (a_i != b_i);
      3'd3:    take_o = (a_i > b_i);
      3'd4:    take_o = (a_i >= b_i);
      default: begin take_o = 1'b0; ok_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pkt_core_bytemem.sv
module pkt_core_bytemem #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ext_we_i,
  input  logic [AW-1:0] ext_addr_i,
  input  logic [7:0]    ext_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [3:0]    rd_nbytes_i,
  output logic [63:0]   rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [3:0]    wr_nbytes_i,
  input  logic [63:0]   wr_data_i
);
  logic [7:0] mem [DEPTH];

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(rd_nbytes_i) &&
          ({4'b0, rd_addr_i} + (AW+4)'(i)) < (AW+4)'(DEPTH))
        rd_data_o[8*i +: 8] = mem[rd_addr_i + AW'(i)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ext_we_i) mem[ext_addr_i] <= ext_data_i;
      if (wr_en_i) begin
        for (int i = 0; i < 8; i++) begin
          if (i < int'(wr_nbytes_i) &&
              ({4'b0, wr_addr_i} + (AW+4)'(i)) < (AW+4)'(DEPTH))
            mem[wr_addr_i + AW'(i)] <= wr_data_i[8*i +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/pkt_core.sv
module pkt_core
  import pkt_core_pkg::*;
#(
  parameter int IMEM_DEPTH  = 64,
  parameter int PKT_BYTES   = 256,
  parameter int STACK_BYTES = 64,
  parameter int WDOG_LIMIT  = 4096,
  parameter int NREGS       = 11,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int PAW = $clog2(PKT_BYTES),
  localparam int SAW = $clog2(STACK_BYTES),
  localparam int LW  = PAW + 1,
  localparam int CW  = $clog2(WDOG_LIMIT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           imem_we_i,
  input  logic [IAW-1:0] imem_addr_i,
  input  logic [63:0]    imem_data_i,
  input  logic           pkt_we_i,
  input  logic [PAW-1:0] pkt_addr_i,
  input  logic [7:0]     pkt_data_i,
  input  logic [LW-1:0]  pkt_len_i,
  input  logic           start_i,
  output logic           done_o,
  output logic [2:0]     verdict_o
);
  logic [63:0]    imem [IMEM_DEPTH];
  state_e         state;
  logic [IAW-1:0] pc;
  logic [CW-1:0]  icnt;
  logic [LW-1:0]  len_q;
  logic [2:0]     verdict_q;
  logic [63:0]    rf [NREGS];

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_data_i;
  end

  instr_t ins;
  logic [3:0]  cls, sub;
  logic        reg_ok, wdog_hit, is_stk, size_ok, oob;
  logic [63:0] a_v, b_v, imm64, ea, alu_y, p_rd, s_rd;
  logic [3:0]  nbytes;
  logic [64:0] acc_end, acc_lim;
  logic        alu_ok, take, cond_ok;
  logic [IAW+12:0] nxt_w;
  logic        fin, bad, wr_rf, pst_en, sst_en;
  logic [2:0]  fin_v;

  assign ins      = instr_t'(imem[pc]);
  assign cls      = ins.opc[7:4];
  assign sub      = ins.opc[3:0];
  assign reg_ok   = (int'(ins.dst) < NREGS) && (int'(ins.src_a) < NREGS) &&
                    (int'(ins.src_b) < NREGS);
  assign wdog_hit = (icnt == CW'(WDOG_LIMIT));
  assign imm64    = {{32{ins.imm[31]}}, ins.imm};
  assign a_v      = reg_ok ? rf[ins.src_a] : '0;
  assign b_v      = (cls == CL_ALU_I || (cls == CL_JMP && sub[3])) ? imm64 :
                    (reg_ok ? rf[ins.src_b] : '0);
  assign is_stk   = sub[3];
  assign nbytes   = acc_bytes(sub[2:0]);
  assign size_ok  = (nbytes != 4'd0);
  assign ea       = a_v + {{52{ins.off[11]}}, ins.off};
  // 65-bit end address: a wrapped negative address stays out of range
  assign acc_end  = {1'b0, ea} + 65'(nbytes);
  assign acc_lim  = is_stk ? 65'(STACK_BYTES) : 65'(len_q);
  assign oob      = acc_end > acc_lim;

  pkt_core_alu u_alu (.op_i(sub), .a_i(a_v), .b_i(b_v), .y_o(alu_y), .ok_o(alu_ok));

  pkt_core_cond u_cond (.op_i(sub[2:0]), .a_i(a_v), .b_i(b_v), .take_o(take),
                        .ok_o(cond_ok));

  pkt_core_bytemem #(.DEPTH(PKT_BYTES)) u_pkt (
    .clk_i, .rst_ni, .clr_i(1'b0),
    .ext_we_i(pkt_we_i), .ext_addr_i(pkt_addr_i), .ext_data_i(pkt_data_i),
    .rd_addr_i(ea[PAW-1:0]), .rd_nbytes_i(nbytes), .rd_data_o(p_rd),
    .wr_en_i(pst_en), .wr_addr_i(ea[PAW-1:0]), .wr_nbytes_i(nbytes),
    .wr_data_i(b_v));

  pkt_core_bytemem #(.DEPTH(STACK_BYTES)) u_stk (
    .clk_i, .rst_ni, .clr_i(state == S_CLEAR),
    .ext_we_i(1'b0), .ext_addr_i('0), .ext_data_i('0),
    .rd_addr_i(ea[SAW-1:0]), .rd_nbytes_i(nbytes), .rd_data_o(s_rd),
    .wr_en_i(sst_en), .wr_addr_i(ea[SAW-1:0]), .wr_nbytes_i(nbytes),
    .wr_data_i(b_v));

  always_comb begin
    fin    = 1'b0;
    fin_v  = V_ABORT;
    wr_rf  = 1'b0;
    pst_en = 1'b0;
    sst_en = 1'b0;
    bad    = !reg_ok || wdog_hit;
    nxt_w  = (IAW+13)'(pc) + 1'b1;
    case (cls)
      CL_ALU_R, CL_ALU_I: begin wr_rf = 1'b1; bad = bad || !alu_ok; end
      CL_LD:   begin wr_rf = 1'b1; bad = bad || !size_ok || oob; end
      CL_ST:   begin pst_en = !is_stk; sst_en = is_stk; bad = bad || !size_ok || oob; end
      CL_JMP: begin
        bad = bad || !cond_ok;
        if (take) nxt_w = (IAW+13)'(pc) + 1'b1 + {{(IAW+1){ins.off[11]}}, ins.off};
      end
      CL_EXIT: begin
        fin = 1'b1;
        if (sub == 4'h8) fin_v = rf[0][2:0];
        else if (!sub[3] && sub[2:0] <= 3'd4) fin_v = sub[2:0];
        else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (!fin && nxt_w >= (IAW+13)'(IMEM_DEPTH)) bad = 1'b1;
    if (state != S_RUN) begin pst_en = 1'b0; sst_en = 1'b0; end
    if (bad) begin
      fin = 1'b1; fin_v = V_ABORT; wr_rf = 1'b0; pst_en = 1'b0; sst_en = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= S_IDLE;
      pc        <= '0;
      icnt      <= '0;
      len_q     <= '0;
      verdict_q <= V_ABORT;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          state <= S_CLEAR;
          len_q <= (pkt_len_i > LW'(PKT_BYTES)) ? LW'(PKT_BYTES) : pkt_len_i;
        end
        S_CLEAR: begin
          for (int i = 0; i < NREGS; i++) rf[i] <= '0;
          rf[2] <= 64'(len_q);
          pc    <= '0;
          icnt  <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          icnt <= icnt + 1'b1;
          if (fin) begin
            verdict_q <= fin_v;
            state     <= S_DONE;
          end else begin
            pc <= nxt_w[IAW-1:0];
            if (wr_rf) rf[ins.dst] <= (cls == CL_LD) ? (is_stk ? s_rd : p_rd) : alu_y;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done_o    = (state == S_DONE);
  assign verdict_o = verdict_q;

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_run_stays_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_RUN) |=> (state == S_RUN || state == S_DONE));
  p_clear_regs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_CLEAR) |=> (rf[0] == '0 && rf[1] == '0 && rf[2] == 64'(len_q)));
  p_wdog_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_RUN) |-> (icnt <= CW'(WDOG_LIMIT)));
  p_oob_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_RUN && (cls == CL_LD || cls == CL_ST) && oob)
      |=> (state == S_DONE && verdict_q == V_ABORT));
  p_ld6_zext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_RUN && cls == CL_LD && sub[2:0] == 3'd3 && !fin)
      |=> (rf[$past(ins.dst)][63:48] == 16'h0));
  p_exit_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_RUN && cls == CL_EXIT && !sub[3] && sub[2:0] <= 3'd4 && !bad)
      |=> (verdict_q == $past(sub[2:0])));
endmodule

// File: tb/pkt_core_tb.sv
module pkt_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_addr = '0;
  logic [63:0] imem_data = '0;
  logic        pkt_we = 1'b0;
  logic [7:0]  pkt_addr = '0;
  logic [7:0]  pkt_data = '0;
  logic [8:0]  pkt_len = '0;
  logic        start = 1'b0;
  logic        done_o;
  logic [2:0]  verdict_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [63:0] prog [64];
  int n = 0;

  always #2 clk = ~clk;

  pkt_core u_dut (
    .clk_i(clk), .rst_ni, .imem_we_i(imem_we), .imem_addr_i(imem_addr),
    .imem_data_i(imem_data), .pkt_we_i(pkt_we), .pkt_addr_i(pkt_addr),
    .pkt_data_i(pkt_data), .pkt_len_i(pkt_len), .start_i(start),
    .done_o, .verdict_o);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] op, input int d, input int a,
                                     input int b, input int off, input int imm);
    return {imm[31:0], off[11:0], b[3:0], a[3:0], d[3:0], op};
  endfunction

  task automatic new_prog();
    for (int i = 0; i < 64; i++) prog[i] = mk(8'h51, 0, 0, 0, 0, 0);
    n = 0;
  endtask

  task automatic em(input logic [7:0] op, input int d, input int a, input int b,
                    input int off, input int imm);
    prog[n] = mk(op, d, a, b, off, imm);
    n++;
  endtask

  // jump to the drop exit at word 63
  task automatic jf(input logic [7:0] op, input int a, input int b, input int imm);
    em(op, 0, a, b, 63 - (n + 1), imm);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 6'(i); imem_data = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic load_pkt();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pkt_we = 1'b1; pkt_addr = 8'(i); pkt_data = 8'(i + 8'h10);
    end
    @(negedge clk);
    pkt_we = 1'b0;
  endtask

  task automatic go(input int len, output logic [2:0] v, output int ncyc);
    @(negedge clk);
    pkt_len = 9'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 0;
    while (!done_o && ncyc < 20000) begin @(negedge clk); ncyc++; end
    chk("R1 done seen", done_o, 1);
    v = verdict_o;
    @(negedge clk);
    chk("R1 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset done", done_o, 0);
    chk("R1 reset verdict", verdict_o, 0);
  endtask

  task automatic t_alu();
    logic [2:0] v; int c;
    new_prog();
    em(8'h10, 4, 2, 0, 0, 14);  jf(8'h4A, 4, 0, 34);  jf(8'h4A, 2, 0, 20);
    em(8'h01, 5, 4, 2, 0, 0);   jf(8'h4A, 5, 0, 14);
    em(8'h04, 6, 4, 5, 0, 0);   jf(8'h4A, 6, 0, 44);
    em(8'h12, 7, 4, 0, 0, 15);  jf(8'h4A, 7, 0, 2);
    em(8'h03, 8, 5, 4, 0, 0);   jf(8'h4A, 8, 0, 46);
    em(8'h11, 9, 4, 0, 0, 40);  em(8'h10, 9, 9, 0, 0, 6); jf(8'h4A, 9, 0, 0);
    em(8'h53, 0, 0, 0, 0, 0);
    load_prog(); go(20, v, c);
    chk("R2 three-operand alu", v, 3);
  endtask

  task automatic t_load();
    logic [2:0] v; int c;
    new_prog();
    em(8'h17, 3, 0, 0, 0, -1);
    em(8'h23, 3, 1, 0, 0, 0);
    em(8'h16, 4, 3, 0, 0, 48);  jf(8'h4A, 4, 0, 0);
    em(8'h16, 4, 3, 0, 0, 32);  jf(8'h4A, 4, 0, 32'h1514);
    em(8'h15, 4, 3, 0, 0, 32);  em(8'h16, 4, 4, 0, 0, 32); jf(8'h4A, 4, 0, 32'h13121110);
    em(8'h20, 5, 1, 0, 0, 0);   jf(8'h4A, 5, 0, 32'h10);
    em(8'h21, 5, 1, 0, 1, 0);   jf(8'h4A, 5, 0, 32'h1211);
    em(8'h22, 5, 1, 0, 2, 0);   jf(8'h4A, 5, 0, 32'h15141312);
    em(8'h24, 5, 1, 0, 0, 0);   em(8'h16, 5, 5, 0, 0, 48); jf(8'h4A, 5, 0, 32'h1716);
    em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(64, v, c);
    chk("R3 load widths and 6-byte zero-extend", v, 2);
  endtask

  task automatic t_store();
    logic [2:0] v; int c;
    new_prog();
    em(8'h17, 3, 0, 0, 0, -1);
    em(8'h3B, 0, 1, 3, 8, 0);
    em(8'h2C, 4, 1, 0, 8, 0);
    em(8'h10, 6, 4, 0, 0, 1);   em(8'h16, 6, 6, 0, 0, 48); jf(8'h4A, 6, 0, 1);
    em(8'h17, 3, 0, 0, 0, 32'h44332211);
    em(8'h32, 0, 1, 3, 4, 0);
    em(8'h20, 5, 1, 0, 5, 0);   jf(8'h4A, 5, 0, 32'h22);
    em(8'h20, 5, 1, 0, 8, 0);   jf(8'h4A, 5, 0, 32'h18);
    em(8'h54, 0, 0, 0, 0, 0);
    load_prog(); go(64, v, c);
    chk("R4 store widths", v, 4);
  endtask

  task automatic t_exit();
    logic [2:0] v; int c;
    new_prog();
    em(8'h17, 0, 0, 0, 0, 2); em(8'h51, 0, 0, 0, 0, 0);
    load_prog(); go(10, v, c);
    chk("R5 exit_drop ignores r0", v, 1);
    new_prog();
    em(8'h17, 0, 0, 0, 0, 4); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(10, v, c);
    chk("R5 exit_pass ignores r0", v, 2);
    new_prog();
    em(8'h17, 0, 0, 0, 0, 27); em(8'h58, 0, 0, 0, 0, 0);
    load_prog(); go(10, v, c);
    chk("R6 plain exit r0=27", v, 3);
    new_prog();
    em(8'h17, 0, 0, 0, 0, 10); em(8'h58, 0, 0, 0, 0, 0);
    load_prog(); go(10, v, c);
    chk("R6 plain exit r0=10", v, 2);
  endtask

  task automatic t_clear();
    logic [2:0] v; int c;
    new_prog();
    em(8'h17, 7, 0, 0, 0, 5); em(8'h17, 3, 0, 0, 0, 9);
    em(8'h38, 0, 1, 3, 0, 0); em(8'h51, 0, 0, 0, 0, 0);
    load_prog(); go(30, v, c);
    chk("R7 first run", v, 1);
    new_prog();
    jf(8'h4A, 7, 0, 0);
    em(8'h28, 5, 1, 0, 0, 0); jf(8'h4A, 5, 0, 0);
    jf(8'h4A, 3, 0, 0); jf(8'h4A, 1, 0, 0); jf(8'h4A, 2, 0, 30);
    em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(30, v, c);
    chk("R7 state cleared between runs", v, 2);
  endtask

  task automatic t_bounds();
    logic [2:0] v; int c;
    new_prog(); em(8'h24, 3, 1, 0, 0, 0); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R8 read ending at length", v, 2);
    new_prog(); em(8'h21, 3, 1, 0, 7, 0); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R8 read crossing length", v, 0);
    new_prog(); em(8'h20, 3, 2, 0, 0, 0); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R8 read at end offset", v, 0);
    new_prog(); em(8'h30, 0, 1, 3, -1, 0); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R8 negative store", v, 0);
  endtask

  task automatic t_wdog();
    logic [2:0] v; int c;
    new_prog(); em(8'h40, 0, 0, 0, -1, 0);
    load_prog(); go(8, v, c);
    chk("R9 endless loop aborted", v, 0);
    chk("R9 abort after limit", (c >= 4096 && c <= 4100) ? 1 : 0, 1);
    for (int k = 0; k < 2; k++) begin
      new_prog();
      em(8'h10, 9, 9, 0, 0, 0);
      em(8'h10, 3, 3, 0, 0, 1);
      em(8'h4A, 0, 3, 0, -2, 2047 + k);
      em(8'h52, 0, 0, 0, 0, 0);
      load_prog(); go(8, v, c);
      chk(k == 0 ? "R9 exactly 4096 instructions" : "R9 4097 instructions", v,
          k == 0 ? 2 : 0);
    end
  endtask

  task automatic t_jump();
    logic [2:0] v; int c;
    new_prog();
    em(8'h17, 3, 0, 0, 0, -1); em(8'h17, 4, 0, 0, 0, 1);
    em(8'h43, 0, 3, 4, 1, 0);  em(8'h40, 0, 0, 0, 59, 0);
    jf(8'h43, 4, 3, 0);
    em(8'h49, 0, 4, 0, 1, 1);  em(8'h40, 0, 0, 0, 56, 0);
    em(8'h4C, 0, 4, 0, 1, 1);  em(8'h40, 0, 0, 0, 54, 0);
    jf(8'h41, 3, 4, 0);
    em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R10 jump conditions", v, 2);
  endtask

  task automatic t_illegal();
    logic [2:0] v; int c;
    new_prog(); em(8'hEE, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R11 undefined opcode", v, 0);
    new_prog(); em(8'h25, 3, 1, 0, 0, 0); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R11 bad size code", v, 0);
    new_prog(); em(8'h17, 12, 0, 0, 0, 1); em(8'h52, 0, 0, 0, 0, 0);
    load_prog(); go(8, v, c);
    chk("R11 bad register", v, 0);
  endtask

  task automatic t_restart();
    int dn = 0;
    new_prog();
    em(8'h10, 3, 3, 0, 0, 1); em(8'h4A, 0, 3, 0, -2, 200); em(8'h53, 0, 0, 0, 0, 0);
    load_prog();
    @(negedge clk); pkt_len = 9'd8; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done_o) dn++;
    end
    chk("R1 restart ignored, one done", dn, 1);
    chk("R1 verdict after re-pulse", verdict_o, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    load_pkt();
    t_alu();
    t_load();
    t_store();
    t_exit();
    t_clear();
    t_bounds();
    t_jump();
    t_illegal();
    t_restart();
    t_wdog();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule